// File: doc/BRIEF.md
# Periodic Actor Timing Controller

This block sequences one periodic control actor. It decides when the actor samples its inputs, when its compute unit is launched and when its results are released. Time is counted in ticks: an external tick strobe, one system clock wide, advances an internal interval counter. The counter never advances on plain clock cycles. A start pulse arms the block with a deadline D and a period T, both counted in ticks. The block then fetches input and launches the compute unit at the start of each period. It releases the output exactly at the D-th tick, so output timing does not depend on how long the computation takes. At the T-th tick it either begins the next period or, if stop is held, goes back to idle.

When D equals T the block uses a single wait state. At the period boundary the old output is released and the new input is fetched in the same step. A separate fused flag marks that step, so the output latch can be ordered ahead of the input latch. If the compute unit is not ready at the deadline instant, the block raises a deadline-miss pulse and goes idle. A configuration with D of zero or D larger than T is rejected when start is presented, and the block stays idle.

Top module: `actor_timing_ctrl`

## Requirements
- R1: After reset the block is idle: `active` is low and every action output is low.
- R2: A start pulse in idle with 1 <= D <= T raises `get_input` and `start_compute` for exactly one cycle in the cycle after the accepting edge, and raises `active`. A start pulse while `active` is high is ignored.
- R3: When D < T, `produce_output` pulses for one cycle after the D-th tick of the period, provided `ready` is high at that tick. It never pulses before that tick.
- R4: When D < T and `ready` is low at the D-th tick, `deadline_miss` pulses for one cycle and the block returns to idle with no output.
- R5: When D < T, at the T-th tick with `stop` low, `get_input` and `start_compute` pulse and the tick count restarts from zero, so the next deadline falls D ticks later.
- R6: When D < T, at the T-th tick with `stop` high, the block returns to idle and raises no action output.
- R7: When D = T, at the T-th tick with `ready` high and `stop` low, `produce_output`, `get_input`, `start_compute` and `fused_step` all pulse in the same cycle, and the block stays active.
- R8: When D = T, at the T-th tick with `ready` low and `stop` low, `deadline_miss` pulses and the block goes idle. With `stop` high the block goes idle silently.
- R9: D and T are captured when start is accepted, and later changes have no effect on the running period. A start with D = 0 or D > T pulses `cfg_error` for one cycle, raises no other output and leaves the block idle.
- R10: The interval counter advances only on cycles where `tick` is high. Any number of clock cycles without a tick produces no action output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timing strobe that advances the interval counter |
| start | input | 1 | Enable pulse; accepted only in idle |
| stop | input | 1 | Level; when high, periodic operation ends at the next period boundary |
| ready | input | 1 | Compute unit has finished its current job |
| cfg_deadline | input | CNT_W | Deadline D in ticks |
| cfg_period | input | CNT_W | Period T in ticks |
| get_input | output | 1 | Pulse: latch the input signals |
| start_compute | output | 1 | Pulse: launch the compute unit |
| produce_output | output | 1 | Pulse: release the output signals |
| fused_step | output | 1 | Pulse: output release and input fetch fall in one step; output goes first |
| deadline_miss | output | 1 | Pulse: compute unit not ready at the deadline |
| cfg_error | output | 1 | Pulse: start refused because of invalid D/T |
| active | output | 1 | High while a period is in progress |

## Verification
Two internal faults matter most: a state register stuck in the wrong wait state, and an interval count that drifts from the tick count. Either one moves the output or input pulse by at least one tick, or drops it, so the fault shows at the ports within one period of the start. A deadline miss that fails to clear the state shows one cycle later as `active` staying high. A count that advances on plain clocks shows during the tick-free stretch as an action pulse that should not be there.

// File: rtl/actor_timing_pkg.sv
package actor_timing_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_DL  = 2'd1,
      ST_WAIT_PER = 2'd2
   } act_state_t;

   typedef struct packed {
      logic fetch;
      logic emit;
      logic fuse;
      logic miss;
      logic err;
   } act_pulse_t;

endpackage

// File: rtl/act_cfg_guard.sv
module act_cfg_guard #(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] deadline,
   input  logic [CNT_W-1:0] period,
   output logic             cfg_ok,
   output logic             cfg_equal
);
   localparam logic [CNT_W-1:0] ZERO = '0;

   always_comb begin
      cfg_ok    = (deadline != ZERO) && (deadline <= period);
      cfg_equal = (deadline == period);
   end
endmodule

// File: rtl/act_interval_cnt.sv
module act_interval_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W:0]   cnt_inc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
   end

   assign cnt_inc = {1'b0, cnt} + 1'b1;
endmodule

// File: rtl/actor_timing_ctrl.sv
module actor_timing_ctrl
   import actor_timing_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             stop,
   input  logic             ready,
   input  logic [CNT_W-1:0] cfg_deadline,
   input  logic [CNT_W-1:0] cfg_period,
   output logic             get_input,
   output logic             start_compute,
   output logic             produce_output,
   output logic             fused_step,
   output logic             deadline_miss,
   output logic             cfg_error,
   output logic             active
);
   localparam int CMP_W = CNT_W + 1;

   if (CNT_W < 2) begin : g_bad_width
      $error("actor_timing_ctrl: CNT_W must be at least 2");
   end

   act_state_t       st_q, st_n;
   logic [CNT_W-1:0] d_q, t_q;
   logic             eq_q;
   logic             cfg_ok, cfg_equal;
   logic             load;
   logic             cnt_clr, cnt_adv;
   logic [CNT_W-1:0] cnt;
   logic [CMP_W-1:0] cnt_inc;
   logic             hit_d, hit_t;
   act_pulse_t       pn, pq;

   act_cfg_guard #(.CNT_W(CNT_W)) u_cfg (
      .deadline (cfg_deadline),
      .period   (cfg_period),
      .cfg_ok   (cfg_ok),
      .cfg_equal(cfg_equal)
   );

   act_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_clr),
      .adv    (cnt_adv),
      .cnt    (cnt),
      .cnt_inc(cnt_inc)
   );

   assign hit_d = tick && (cnt_inc == {1'b0, d_q});
   assign hit_t = tick && (cnt_inc == {1'b0, t_q});

   // Next-state and action decode
   always_comb begin
      st_n    = st_q;
      pn      = '0;
      load    = 1'b0;
      cnt_clr = 1'b0;
      cnt_adv = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               if (cfg_ok) begin
                  load     = 1'b1;
                  pn.fetch = 1'b1;
                  cnt_clr  = 1'b1;
                  st_n     = ST_WAIT_DL;
               end else begin
                  pn.err = 1'b1;
               end
            end
         end
         ST_WAIT_DL: begin
            if (eq_q) begin
               if (hit_t) begin
                  if (stop) begin
                     st_n = ST_IDLE;
                  end else if (ready) begin
                     pn.emit  = 1'b1;
                     pn.fetch = 1'b1;
                     pn.fuse  = 1'b1;
                     cnt_clr  = 1'b1;
                  end else begin
                     pn.miss = 1'b1;
                     st_n    = ST_IDLE;
                  end
               end else begin
                  cnt_adv = tick;
               end
            end else begin
               if (hit_d) begin
                  if (ready) begin
                     pn.emit = 1'b1;
                     cnt_adv = 1'b1;
                     st_n    = ST_WAIT_PER;
                  end else begin
                     pn.miss = 1'b1;
                     st_n    = ST_IDLE;
                  end
               end else begin
                  cnt_adv = tick;
               end
            end
         end
         ST_WAIT_PER: begin
            if (hit_t) begin
               if (stop) begin
                  st_n = ST_IDLE;
               end else begin
                  pn.fetch = 1'b1;
                  cnt_clr  = 1'b1;
                  st_n     = ST_WAIT_DL;
               end
            end else begin
               cnt_adv = tick;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         d_q  <= '0;
         t_q  <= '0;
         eq_q <= 1'b0;
      end else begin
         st_q <= st_n;
         if (load) begin
            d_q  <= cfg_deadline;
            t_q  <= cfg_period;
            eq_q <= cfg_equal;
         end
      end
   end

   assign active = (st_q != ST_IDLE);

   // Output variant: registered pulses or direct Mealy outputs
   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pq <= '0;
         else        pq <= pn;
      end

      AST_EMIT_AFTER_READY:  assert property (@(posedge clk) disable iff (!rst_n)
         produce_output |-> $past(ready));                             // R3
      AST_EMIT_ON_TICK:      assert property (@(posedge clk) disable iff (!rst_n)
         produce_output |-> $past(tick));                              // R10
      AST_MISS_ON_TICK:      assert property (@(posedge clk) disable iff (!rst_n)
         deadline_miss |-> $past(tick));                               // R10
      AST_MISS_ENDS_RUN:     assert property (@(posedge clk) disable iff (!rst_n)
         deadline_miss |-> !active);                                   // R4
      AST_ERR_STAYS_IDLE:    assert property (@(posedge clk) disable iff (!rst_n)
         cfg_error |-> (!active && !$past(active)));                   // R9
   end else begin : g_out_comb
      assign pq = pn;

      AST_EMIT_AFTER_READY:  assert property (@(posedge clk) disable iff (!rst_n)
         produce_output |-> ready);                                    // R3
      AST_EMIT_ON_TICK:      assert property (@(posedge clk) disable iff (!rst_n)
         produce_output |-> tick);                                     // R10
      AST_MISS_ENDS_RUN:     assert property (@(posedge clk) disable iff (!rst_n)
         deadline_miss |=> !active);                                   // R4
   end

   assign get_input      = pq.fetch;
   assign start_compute  = pq.fetch;
   assign produce_output = pq.emit;
   assign fused_step     = pq.fuse;
   assign deadline_miss  = pq.miss;
   assign cfg_error      = pq.err;

   AST_NO_OVERFLOW:    assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt <= t_q));                                        // R5
   AST_MISS_NO_EMIT:   assert property (@(posedge clk) disable iff (!rst_n)
      !(deadline_miss && produce_output));                             // R4
   AST_FUSE_WITH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      fused_step |-> (produce_output && get_input));                   // R7
   AST_QUIET_NO_TICK:  assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tick && !$past(start)) |=> $stable(cnt));            // R10
endmodule

// File: tb/sim_actor_timing_ctrl.sv
module sim_actor_timing_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0, start = 1'b0, stop = 1'b0, ready = 1'b0;
   logic [W-1:0] cfg_d = '0, cfg_t = '0;
   logic         gi, sc, po, fu, dm, er, act;
   int           checks = 0;
   int           errors = 0;
   bit           done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   actor_timing_ctrl #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
      .ready(ready), .cfg_deadline(cfg_d), .cfg_period(cfg_t),
      .get_input(gi), .start_compute(sc), .produce_output(po),
      .fused_step(fu), .deadline_miss(dm), .cfg_error(er), .active(act)
   );

   task automatic chk1(string req, string nm, logic a, logic e);
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, nm, a, e, $time);
      end
   endtask

   // expected: fetch, emit, fuse, miss, err, active
   task automatic expect_out(string req, logic e_gi, logic e_po, logic e_fu,
                             logic e_dm, logic e_er, logic e_act);
      chk1(req, "get_input", gi, e_gi);
      chk1(req, "start_compute", sc, e_gi);
      chk1(req, "produce_output", po, e_po);
      chk1(req, "fused_step", fu, e_fu);
      chk1(req, "deadline_miss", dm, e_dm);
      chk1(req, "cfg_error", er, e_er);
      chk1(req, "active", act, e_act);
   endtask

   // all drives happen 1 time unit after a rising edge
   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic do_tick();
      tick = 1'b1; cyc(); tick = 1'b0;
   endtask

   task automatic do_start();
      start = 1'b1; cyc(); start = 1'b0;
   endtask

   task automatic t_reset();
      expect_out("R1", 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_split_run();
      cfg_d = 8'd3; cfg_t = 8'd5; ready = 1'b0; stop = 1'b0;
      do_start();  expect_out("R2", 1, 0, 0, 0, 0, 1);
      cyc();       expect_out("R2", 0, 0, 0, 0, 0, 1);
      do_start();  expect_out("R2", 0, 0, 0, 0, 0, 1);   // start while active ignored
      cfg_d = 8'd1; cfg_t = 8'd2;                        // R9: late change ignored
      for (int i = 0; i < 10; i++) begin
         cyc(); expect_out("R10", 0, 0, 0, 0, 0, 1);
      end
      do_tick();   expect_out("R9", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R3", 0, 0, 0, 0, 0, 1);
      ready = 1'b1;
      do_tick();   expect_out("R3", 0, 1, 0, 0, 0, 1);
      cyc();       expect_out("R3", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R5", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R5", 1, 0, 0, 0, 0, 1);
      cyc();       expect_out("R5", 0, 0, 0, 0, 0, 1);
      ready = 1'b0;
      do_tick();   expect_out("R5", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R5", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R4", 0, 0, 0, 1, 0, 0);
      cyc();       expect_out("R4", 0, 0, 0, 0, 0, 0);
      do_tick();   expect_out("R4", 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_split_stop();
      cfg_d = 8'd3; cfg_t = 8'd5; ready = 1'b1; stop = 1'b0;
      do_start();  expect_out("R2", 1, 0, 0, 0, 0, 1);
      do_tick(); do_tick();
      do_tick();   expect_out("R3", 0, 1, 0, 0, 0, 1);
      stop = 1'b1;                                       // stop level before boundary
      do_tick();   expect_out("R6", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R6", 0, 0, 0, 0, 0, 0);
      stop = 1'b0;
      do_tick();   expect_out("R6", 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_equal();
      cfg_d = 8'd2; cfg_t = 8'd2; ready = 1'b1; stop = 1'b0;
      do_start();  expect_out("R2", 1, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R7", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R7", 1, 1, 1, 0, 0, 1);
      cyc();       expect_out("R7", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R7", 0, 0, 0, 0, 0, 1);
      ready = 1'b0;
      do_tick();   expect_out("R8", 0, 0, 0, 1, 0, 0);
      ready = 1'b1;
      do_start();  expect_out("R2", 1, 0, 0, 0, 0, 1);
      stop = 1'b1;
      do_tick();   expect_out("R8", 0, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R8", 0, 0, 0, 0, 0, 0);
      stop = 1'b0;
   endtask

   task automatic t_config();
      cfg_d = 8'd0; cfg_t = 8'd4;
      do_start();  expect_out("R9", 0, 0, 0, 0, 1, 0);
      cyc();       expect_out("R9", 0, 0, 0, 0, 0, 0);
      cfg_d = 8'd5; cfg_t = 8'd3;
      do_start();  expect_out("R9", 0, 0, 0, 0, 1, 0);
      do_tick();   expect_out("R9", 0, 0, 0, 0, 0, 0);
      cfg_d = 8'd1; cfg_t = 8'd1; ready = 1'b1;
      do_start();  expect_out("R9", 1, 0, 0, 0, 0, 1);
      do_tick();   expect_out("R7", 1, 1, 1, 0, 0, 1);
      stop = 1'b1;
      do_tick();   expect_out("R8", 0, 0, 0, 0, 0, 0);
      stop = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cyc();
      t_reset();
      t_split_run();
      t_split_stop();
      t_equal();
      t_config();
      repeat (2) cyc();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule